// File: doc/BRIEF.md
# Interrupt Source Qualification and Routing

This block keeps the configuration and pending state for a bank of interrupt inputs and decides, for each input, whether it may be delivered and to which processor targets. Every source owns a control word and a target-enable word. Both are written and read through a small register port. The control word holds the mask, activity, delivery-mode and sense flags, a 5-bit priority and a vector. The target-enable word selects the targets the source may reach.

Evaluation is event driven. A change on a source's input line, or a write to either of its words, queues that source for evaluation. The block evaluates one queued source per cycle, lowest index first. An eligible source produces a one-cycle offer strobe on each chosen target, and each strobe carries the source index. In directed mode the offer goes to every enabled target. In distributed mode it goes to one target, found by a rotating scan that starts just after the target the source last reached. A downstream target that takes the interrupt pulses the per-source acceptance strobe. That strobe sets the source's read-only activity flag, which holds off further delivery, and it also drops a latched edge event.

Top module: `irq_route`

## Requirements
- R1: After reset every control word reads 0xA0000000, every target-enable word reads 0, and no offer is driven.
- R2: Writing a control word replaces every bit except bit 30 (activity), which keeps its previous value. The word is addressed with reg_addr_i bit 0 = 0 and the source index in the upper bits.
- R3: Writing a target-enable word (reg_addr_i bit 0 = 1) keeps only bits 31:30 and bits [N_TGT-1:0]. All other bits read back as 0.
- R4: A source is not offered when it is not pending, when its mask (bit 31) is 1, when its priority (bits 20:16) is 0, or when its target-enable word is 0.
- R5: A pulse on accept_i[s] sets bit 30 of source s. While bit 30 is set, the source is not offered.
- R6: With bit 22 = 1 (level sense), pending follows the input level. A low level also clears the activity flag.
- R7: With bit 22 = 0 (edge sense), a rising input sets pending. A falling input leaves it set.
- R8: With bit 29 = 0 (directed), the source is offered in the same cycle to every enabled target, and each offered target carries the source index on offer_src_o.
- R9: With bit 29 = 1 (distributed), targets are scanned from the last-served target plus one, wrapping at N_TGT. The source goes to the first enabled target found, and that target becomes the last-served target. The last-served target is 0 after reset.
- R10: When the enable bits hold exactly one set bit and that bit is the last-served target, the source is offered to that target alone, in either mode, and the last-served target is unchanged.
- R11: An input change or a register write sampled at clock edge k yields its offer at edge k+1. When several sources are queued, they are served one per cycle, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Raw interrupt input lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | SRC_W+1 | {source index, word select}; select 0 = control, 1 = target-enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| accept_i | input | N_SRC | Per-source acceptance strobe from the targets |
| offer_o | output | N_TGT | Per-target offer strobe, one cycle wide |
| offer_src_o | output | N_TGT x SRC_W | Source index carried with each offer |

## Verification
A write or an input change sampled at edge k updates the stored words, the pending flag and the activity flag at that same edge, so read data reflects the change in the following cycle. The resulting offer is registered one edge later, at k+1. When a lower-index source is queued in the same cycle, the offer moves back one edge for each such source. The bench drives every stimulus at a falling edge and samples each result at the falling edge that follows the edge where the result is due. It checks the cycles where an offer is expected to be absent as well as those where one is expected. A distributed-mode source with a single enable bit equal to its last-served target tells the single-target rule apart from the rotating scan.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned MASK_BIT  = 31;
  localparam int unsigned ACT_BIT   = 30;
  localparam int unsigned MODE_BIT  = 29;
  localparam int unsigned SENSE_BIT = 22;
  localparam int unsigned PRIO_LO   = 16;
  localparam int unsigned PRIO_HI   = 20;
  localparam logic [31:0] CTL_RST   = 32'hA000_0000;
  localparam logic [31:0] ACT_MASK  = 32'h4000_0000;
  localparam logic [31:0] DST_HI    = 32'hC000_0000;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_route_pkg::*;
#(
  parameter int unsigned N_TGT = 4,
  parameter int unsigned TGT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             ctl_we_i,
  input  logic             dst_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             accept_i,
  input  logic             last_we_i,
  input  logic [TGT_W-1:0] last_i,
  output logic [31:0]      ctl_o,
  output logic [31:0]      dst_o,
  output logic             pend_o,
  output logic [TGT_W-1:0] last_o,
  output logic             trig_o
);
  localparam logic [31:0] DST_KEEP = DST_HI | ((32'd1 << N_TGT) - 32'd1);

  logic             irq_q, pend_q;
  logic [31:0]      ctl_q, ctl_d, dst_q;
  logic [TGT_W-1:0] last_q;
  logic             level;

  assign level = ctl_q[SENSE_BIT];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we_i) ctl_d = (wdata_i & ~ACT_MASK) | (ctl_q & ACT_MASK);
    if (level && !irq_i) ctl_d[ACT_BIT] = 1'b0;
    else if (accept_i)   ctl_d[ACT_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
      ctl_q  <= CTL_RST;
      dst_q  <= '0;
      last_q <= '0;
    end else begin
      irq_q <= irq_i;
      ctl_q <= ctl_d;
      if (dst_we_i) dst_q <= wdata_i & DST_KEEP;
      if (level)                  pend_q <= irq_i;
      else if (irq_i && !irq_q)   pend_q <= 1'b1;
      else if (accept_i)          pend_q <= 1'b0;
      if (last_we_i) last_q <= last_i;
    end
  end

  assign trig_o = (irq_i != irq_q) | ctl_we_i | dst_we_i;
  assign ctl_o  = ctl_q;
  assign dst_o  = dst_q;
  assign pend_o = pend_q;
  assign last_o = last_q;

  AST_ACT_READONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !accept_i && !(level && !irq_i)) |=> (ctl_q[ACT_BIT] == $past(ctl_q[ACT_BIT]))); // R5
  AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level |=> (pend_q == $past(irq_i))); // R6
  AST_LAST_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_we_i |-> dst_q[last_i]); // R9
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_route_tgt.sv
module irq_route_tgt #(
  parameter int unsigned N_TGT = 4,
  parameter int unsigned TGT_W = 2
) (
  input  logic [N_TGT-1:0] en_i,
  input  logic             dist_i,
  input  logic [TGT_W-1:0] last_i,
  output logic [N_TGT-1:0] tgt_o,
  output logic             last_we_o,
  output logic [TGT_W-1:0] last_o
);
  always_comb begin
    int idx;
    tgt_o     = '0;
    last_we_o = 1'b0;
    last_o    = last_i;
    idx       = 0;
    if (en_i == (N_TGT'(1) << last_i)) begin
      tgt_o = en_i;
    end else if (!dist_i) begin
      tgt_o = en_i;
    end else begin
      // descending offsets: the nearest enabled target after last_i wins
      for (int off = N_TGT - 1; off >= 1; off--) begin
        idx = int'(last_i) + off;
        if (idx >= int'(N_TGT)) idx = idx - int'(N_TGT);
        if (en_i[idx]) begin
          tgt_o      = '0;
          tgt_o[idx] = 1'b1;
          last_we_o  = 1'b1;
          last_o     = TGT_W'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned N_TGT = 4,
  localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_SRC-1:0]            irq_i,
  input  logic                        reg_we_i,
  input  logic [SRC_W:0]              reg_addr_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  input  logic [N_SRC-1:0]            accept_i,
  output logic [N_TGT-1:0]            offer_o,
  output logic [N_TGT-1:0][SRC_W-1:0] offer_src_o
);
  logic [31:0]      ctl  [N_SRC];
  logic [31:0]      dst  [N_SRC];
  logic [TGT_W-1:0] last [N_SRC];
  logic [N_SRC-1:0] pend, trig, eval_req_q, sel_oh;
  logic [SRC_W-1:0] addr_src, sel_idx;
  logic             sel_vld, elig;
  logic [31:0]      sel_dst;
  logic             sel_mask, sel_act, sel_mode, sel_pend;
  logic [4:0]       sel_prio;
  logic [TGT_W-1:0] sel_last, route_last;
  logic [N_TGT-1:0] route_tgt;
  logic             route_last_we;

  assign addr_src = reg_addr_i[SRC_W:1];

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    irq_src_slot #(.N_TGT(N_TGT), .TGT_W(TGT_W)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i[s]),
      .ctl_we_i  (reg_we_i && !reg_addr_i[0] && (addr_src == SRC_W'(s))),
      .dst_we_i  (reg_we_i &&  reg_addr_i[0] && (addr_src == SRC_W'(s))),
      .wdata_i   (reg_wdata_i),
      .accept_i  (accept_i[s]),
      .last_we_i (elig && route_last_we && (sel_idx == SRC_W'(s))),
      .last_i    (route_last),
      .ctl_o     (ctl[s]),
      .dst_o     (dst[s]),
      .pend_o    (pend[s]),
      .last_o    (last[s]),
      .trig_o    (trig[s])
    );
  end

  assign reg_rdata_o = reg_addr_i[0] ? dst[addr_src] : ctl[addr_src];

  irq_pick #(.N(N_SRC), .IDX_W(SRC_W)) i_pick (
    .req_i (eval_req_q),
    .vld_o (sel_vld),
    .idx_o (sel_idx)
  );

  always_comb begin
    sel_dst  = dst[sel_idx];
    sel_mask = ctl[sel_idx][MASK_BIT];
    sel_act  = ctl[sel_idx][ACT_BIT];
    sel_mode = ctl[sel_idx][MODE_BIT];
    sel_prio = ctl[sel_idx][PRIO_HI:PRIO_LO];
    sel_pend = pend[sel_idx];
    sel_last = last[sel_idx];
    sel_oh   = sel_vld ? (N_SRC'(1) << sel_idx) : '0;
    elig     = sel_vld && sel_pend && !sel_mask && (sel_prio != '0)
               && !sel_act && (sel_dst != '0);
  end

  irq_route_tgt #(.N_TGT(N_TGT), .TGT_W(TGT_W)) i_tgt (
    .en_i      (sel_dst[N_TGT-1:0]),
    .dist_i    (sel_mode),
    .last_i    (sel_last),
    .tgt_o     (route_tgt),
    .last_we_o (route_last_we),
    .last_o    (route_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_req_q  <= '0;
      offer_o     <= '0;
      offer_src_o <= '0;
    end else begin
      eval_req_q <= (eval_req_q & ~sel_oh) | trig;
      offer_o    <= elig ? route_tgt : '0;
      if (elig) begin
        for (int t = 0; t < int'(N_TGT); t++) offer_src_o[t] <= sel_idx;
      end
    end
  end

  AST_OFFER_IN_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|offer_o) |-> ((offer_o & ~$past(sel_dst[N_TGT-1:0])) == '0)); // R8
  AST_OFFER_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|offer_o) |-> (!$past(sel_mask) && ($past(sel_prio) != '0) && !$past(sel_act))); // R4
  AST_DIST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vld && sel_mode) |-> $onehot0(route_tgt)); // R9
  AST_REQ_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vld && !trig[sel_idx]) |=> !eval_req_q[$past(sel_idx)]); // R11
endmodule

// File: tb/test_irq_route.sv
`timescale 1ns/1ps
module test_irq_route;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      irq = '0;
  logic             we = 1'b0;
  logic [4:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [15:0]      accept = '0;
  logic [3:0]       offer;
  logic [3:0][3:0]  offer_src;
  int               n_run = 0;
  int               n_fail = 0;
  bit               done = 1'b0;

  irq_route i_irq_route (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .accept_i(accept),
    .offer_o(offer), .offer_src_o(offer_src)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk_ctl(bit m, bit md, bit sn, logic [4:0] pr, logic [7:0] v);
    return {m, 1'b0, md, 6'b0, sn, 1'b0, pr, 8'b0, v};
  endfunction
  function automatic logic [31:0] exp_ctl(bit act, logic [31:0] w);
    return (w & 32'hBFFF_FFFF) | (act ? 32'h4000_0000 : 32'h0);
  endfunction
  function automatic logic [31:0] exp_dst(logic [31:0] w);
    return w & 32'hC000_000F;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] s, bit sel, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = {s, sel}; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd_chk(logic [3:0] s, bit sel, logic [31:0] exp, string req);
    @(negedge clk); addr = {s, sel}; #1;
    chk(rdata == exp, req, rdata, exp);
  endtask
  task automatic set_irq(int s, bit v);
    @(negedge clk); irq[s] = v;
    @(negedge clk);
  endtask
  task automatic acc(int s);
    @(negedge clk); accept[s] = 1'b1;
    @(negedge clk); accept[s] = 1'b0;
  endtask
  task automatic exp_offer(logic [3:0] m, logic [3:0] s, string req);
    @(negedge clk);
    chk(offer == m, req, 32'(offer), 32'(m));
    for (int t = 0; t < 4; t++)
      if (m[t]) chk(offer_src[t] == s, req, 32'(offer_src[t]), 32'(s));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  s;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(offer == 4'b0, "R1 offer", 32'(offer), 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd_chk(4'(i), 1'b0, 32'hA000_0000, "R1 ctl");
      rd_chk(4'(i), 1'b1, 32'h0, "R1 dst");
    end
    // R2 / R3 random readback
    for (int i = 0; i < 24; i++) begin
      s = 4'($urandom % 16);
      d = $urandom;
      wr(s, 1'b0, d);
      rd_chk(s, 1'b0, exp_ctl(1'b0, d), "R2 ctl write");
      d = $urandom;
      wr(s, 1'b1, d);
      rd_chk(s, 1'b1, exp_dst(d), "R3 dst write");
    end
    // R8 directed, level source 3
    wr(4'd3, 1'b1, 32'h0000_000B);
    wr(4'd3, 1'b0, mk_ctl(0, 0, 1, 5'd5, 8'h33));
    set_irq(3, 1'b1);
    exp_offer(4'b1011, 4'd3, "R8 directed multicast");
    // R5 activity
    acc(3);
    rd_chk(4'd3, 1'b0, exp_ctl(1'b1, mk_ctl(0, 0, 1, 5'd5, 8'h33)), "R5 activity set");
    wr(4'd3, 1'b0, mk_ctl(0, 0, 1, 5'd5, 8'h33));
    exp_offer(4'b0000, 4'd0, "R5 activity blocks");
    rd_chk(4'd3, 1'b0, exp_ctl(1'b1, mk_ctl(0, 0, 1, 5'd5, 8'h33)), "R5 activity read-only");
    // R6 level low clears activity
    set_irq(3, 1'b0);
    exp_offer(4'b0000, 4'd0, "R6 low level not pending");
    rd_chk(4'd3, 1'b0, mk_ctl(0, 0, 1, 5'd5, 8'h33), "R6 activity cleared");
    set_irq(3, 1'b1);
    exp_offer(4'b1011, 4'd3, "R6 redelivery");
    set_irq(3, 1'b0);
    exp_offer(4'b0000, 4'd0, "R6 pending follows low");
    wr(4'd3, 1'b0, mk_ctl(0, 0, 1, 5'd5, 8'h33));
    exp_offer(4'b0000, 4'd0, "R4 not pending");
    // R4 qualifiers, source 5
    wr(4'd5, 1'b1, 32'h0000_0001);
    wr(4'd5, 1'b0, mk_ctl(1, 0, 1, 5'd3, 8'h55));
    set_irq(5, 1'b1);
    exp_offer(4'b0000, 4'd0, "R4 masked");
    wr(4'd5, 1'b0, mk_ctl(0, 0, 1, 5'd0, 8'h55));
    exp_offer(4'b0000, 4'd0, "R4 priority zero");
    wr(4'd5, 1'b1, 32'h0000_0000);
    exp_offer(4'b0000, 4'd0, "R4 dst zero a");
    wr(4'd5, 1'b0, mk_ctl(0, 0, 1, 5'd3, 8'h55));
    exp_offer(4'b0000, 4'd0, "R4 dst zero b");
    wr(4'd5, 1'b1, 32'h0000_0004);
    exp_offer(4'b0100, 4'd5, "R4 qualified");
    // R7 edge source 7
    wr(4'd7, 1'b1, 32'h0000_0002);
    wr(4'd7, 1'b0, mk_ctl(0, 0, 0, 5'd2, 8'h77));
    set_irq(7, 1'b1);
    exp_offer(4'b0010, 4'd7, "R7 rising edge");
    set_irq(7, 1'b0);
    exp_offer(4'b0010, 4'd7, "R7 falling keeps pending");
    acc(7);
    set_irq(7, 1'b1);
    exp_offer(4'b0000, 4'd0, "R5 edge blocked by activity");
    rd_chk(4'd7, 1'b0, exp_ctl(1'b1, mk_ctl(0, 0, 0, 5'd2, 8'h77)), "R5 edge activity");
    // R9 distributed rotation, source 9
    wr(4'd9, 1'b1, 32'h0000_000B);
    wr(4'd9, 1'b0, mk_ctl(0, 1, 1, 5'd4, 8'h99));
    set_irq(9, 1'b1);
    exp_offer(4'b0010, 4'd9, "R9 first from last+1");
    wr(4'd9, 1'b0, mk_ctl(0, 1, 1, 5'd4, 8'h99));
    exp_offer(4'b1000, 4'd9, "R9 skip disabled");
    wr(4'd9, 1'b0, mk_ctl(0, 1, 1, 5'd4, 8'h99));
    exp_offer(4'b0001, 4'd9, "R9 wrap");
    wr(4'd9, 1'b0, mk_ctl(0, 1, 1, 5'd4, 8'h99));
    exp_offer(4'b0010, 4'd9, "R9 rotate again");
    // R10 single enable equal to last served (last = 1)
    wr(4'd9, 1'b1, 32'h0000_0002);
    exp_offer(4'b0010, 4'd9, "R10 single target");
    wr(4'd9, 1'b0, mk_ctl(0, 1, 1, 5'd4, 8'h99));
    exp_offer(4'b0010, 4'd9, "R10 last unchanged");
    // R11 ordering of simultaneous requests
    wr(4'd2, 1'b1, 32'h0000_0004);
    wr(4'd2, 1'b0, mk_ctl(0, 0, 1, 5'd1, 8'h22));
    wr(4'd12, 1'b1, 32'h0000_0001);
    wr(4'd12, 1'b0, mk_ctl(0, 0, 1, 5'd1, 8'hC2));
    @(negedge clk); irq[2] = 1'b1; irq[12] = 1'b1;
    @(negedge clk);
    exp_offer(4'b0100, 4'd2, "R11 lower index first");
    exp_offer(4'b0001, 4'd12, "R11 next cycle");
    exp_offer(4'b0000, 4'd0, "R11 queue drained");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule